// File: doc/BRIEF.md
# Scatter-Gather Descriptor Segmenter

The block turns a list of memory fragments, each given as a 32-bit bus address and a byte length, into a table of two-word region descriptors. It writes the table word by word through a simple write port into descriptor memory. A region never straddles a 64 KiB address boundary, so a fragment that crosses one is cut at the boundary. In standard format, a full 64 KiB region would carry a count field of zero. Such a region is written as two 32 KiB descriptors instead. The last descriptor of a successful standard table has its top bit set.

A controller pulses `start` and picks the format with `alt_mode`, which is sampled on that pulse. It then streams fragments over a valid/ready handshake, marking the final one with `seg_last`. When the table is complete, the block raises `done` together with the entry count and status flags. These stay stable until the next `start`. A table that would need more than `MAX_ENTRIES` descriptors is abandoned with a zero count. A misaligned fragment is also abandoned with a zero count. In both cases the rest of the fragment list is still consumed, so that the stream stays in step. The alternate format stores a word-based count in the upper half of the count word, never splits a full 64 KiB region, and writes no end marker.

Top module: `sgd_segmenter`

## Requirements
- R1: Descriptor n occupies word index 2n (region address) and 2n+1 (count word). Each descriptor is written address word first, then count word, and descriptors are written in ascending n through `wr_en`/`wr_idx`/`wr_data`.
- R2: Each region length is the smaller of the bytes left in the fragment and 0x10000 minus the low 16 bits of the current address. The next region starts right after it.
- R3: In standard format the count word holds the region length in bits 15:0, with bits 30:16 zero.
- R4: In standard format a region of exactly 0x10000 bytes at address A is written as two descriptors: (A, 0x8000) then (A+0x8000, 0x8000).
- R5: After the last descriptor of a successful, non-empty standard table, the block rewrites that descriptor's count word at its own index with bit 31 set. This is the final write of the table.
- R6: If a descriptor is needed when MAX_ENTRIES descriptors already exist, nothing more is written. The block finishes with `fail`=1 and `count`=0, writes no end marker, and accepts the remaining fragments up to the one with `seg_last`.
- R7: In alternate format the count word is ((length>>2)-1)<<16. A 0x10000-byte region stays one descriptor, and no end marker is written.
- R8: A zero-length fragment emits no descriptor. A table that ends with no descriptors finishes with `empty`=1, `fail`=0, `count`=0 and no writes.
- R9: A fragment whose address or length has bit 0 set (standard), or has either of bits 1:0 set (alternate), stops the table. The block sets `align_err`=1, `fail`=1, `count`=0 and writes nothing more. Descriptors written before stay, and the remaining fragments are consumed as in R6.
- R10: On success `count` equals the number of descriptors. The values of `done`, `fail`, `empty`, `align_err` and `count` hold from completion until the next accepted `start`, which clears them.
- R11: `seg_ready` is high only while the block waits for a fragment, and a fragment is taken only when `seg_valid` and `seg_ready` are both high. The block never writes in a cycle where `seg_ready` is high. It ignores `seg_valid` and `start` outside a table and while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new table (accepted when idle) |
| alt_mode | input | 1 | Table format, sampled with `start`: 0 standard, 1 alternate |
| seg_valid | input | 1 | Fragment present |
| seg_ready | output | 1 | Block takes the fragment this cycle if valid |
| seg_addr | input | 32 | Fragment bus address |
| seg_len | input | LEN_W | Fragment byte length |
| seg_last | input | 1 | Final fragment of the table |
| wr_en | output | 1 | Descriptor memory write strobe |
| wr_idx | output | IDX_W | Descriptor memory word index |
| wr_data | output | 32 | Word written |
| done | output | 1 | Table finished (held) |
| fail | output | 1 | Table abandoned (held) |
| empty | output | 1 | Table finished with no descriptors (held) |
| align_err | output | 1 | Abandoned because of misalignment (held) |
| count | output | CNT_W | Number of descriptors, zero on failure (held) |

## Verification
The forced halving of a full 64 KiB region and the table-size limit can meet on the same descriptor. This happens when the first half fits in the last free slot and the second half has no room. The bench provokes this by filling all but one slot with small fragments and then sending a boundary-aligned 64 KiB fragment that is not the last one. The scoreboard expects the first half to be written with its 0x8000 count. After that it expects no further writes and no end marker, a zero count with `fail` set, and the trailing fragment to be drained.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CHUNK_W  = 17;
    localparam logic [CHUNK_W-1:0] WINDOW = 17'h10000;
    localparam logic [WORD_W-1:0]  HALF_WINDOW = 32'h0000_8000;
    localparam int unsigned EOT_BIT  = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ADDR,
        ST_CNT,
        ST_ADDR2,
        ST_CNT2,
        ST_FIN,
        ST_DRAIN
    } seg_state_e;

    typedef struct packed {
        logic [CHUNK_W-1:0] len;
        logic               split;
        logic [WORD_W-1:0]  word;
    } chunk_t;

    typedef struct packed {
        logic done;
        logic fail;
        logic empty;
        logic align_err;
    } result_flags_t;

    function automatic logic misaligned(input logic alt,
                                        input logic [1:0] addr_lo,
                                        input logic [1:0] len_lo);
        if (alt)
            return (|addr_lo) | (|len_lo);
        return addr_lo[0] | len_lo[0];
    endfunction

    function automatic logic [WORD_W-1:0] std_word(input logic [15:0] len_lo);
        return {16'd0, len_lo};
    endfunction

    function automatic logic [WORD_W-1:0] alt_word(input logic [14:0] words);
        return {1'b0, words - 15'd1, 16'd0};
    endfunction

endpackage

// File: rtl/sgd_chunker.sv
module sgd_chunker
    import sgd_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic             alt,
    input  logic [15:0]      addr_lo,
    input  logic [LEN_W-1:0] rem,
    output chunk_t           chunk
);

    logic [CHUNK_W-1:0] to_bound;
    logic [CHUNK_W-1:0] len;

    always_comb begin
        to_bound = WINDOW - {1'b0, addr_lo};
        if (rem < LEN_W'(to_bound))
            len = rem[CHUNK_W-1:0];
        else
            len = to_bound;
        chunk.len   = len;
        chunk.split = !alt && (len[15:0] == 16'd0);
        chunk.word  = alt ? alt_word(len[16:2]) : std_word(len[15:0]);
    end

endmodule

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
    import sgd_pkg::*;
#(
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned MAX_ENTRIES = 8,
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              alt_mode,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    input  chunk_t            chunk,
    output logic              alt_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  rem,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output result_flags_t     flags,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);

    seg_state_e         state;
    chunk_t             chunk_q;
    logic               cur_last;
    logic [CNT_W-1:0]   n_q;
    logic [IDX_W-1:0]   last_idx;
    logic [WORD_W-1:0]  last_word;
    logic               seg_end;
    logic [IDX_W-1:0]   addr_slot;
    logic [IDX_W-1:0]   cnt_slot;

    assign seg_end   = (rem == LEN_W'(chunk_q.len));
    assign addr_slot = IDX_W'({n_q, 1'b0});
    assign cnt_slot  = IDX_W'({n_q, 1'b1});
    assign seg_ready = (state == ST_WAIT) || (state == ST_DRAIN);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = '0;
        unique case (state)
            ST_ADDR: if (n_q != LIMIT) begin
                wr_en   = 1'b1;
                wr_idx  = addr_slot;
                wr_data = cur_addr;
            end
            ST_CNT: begin
                wr_en   = 1'b1;
                wr_idx  = cnt_slot;
                wr_data = chunk_q.split ? HALF_WINDOW : chunk_q.word;
            end
            ST_ADDR2: if (n_q != LIMIT) begin
                wr_en   = 1'b1;
                wr_idx  = addr_slot;
                wr_data = cur_addr + HALF_WINDOW;
            end
            ST_CNT2: begin
                wr_en   = 1'b1;
                wr_idx  = cnt_slot;
                wr_data = HALF_WINDOW;
            end
            ST_FIN: if (n_q != '0 && !alt_q) begin
                wr_en   = 1'b1;
                wr_idx  = last_idx;
                wr_data = last_word | (WORD_W'(1) << EOT_BIT);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            alt_q     <= 1'b0;
            cur_addr  <= '0;
            rem       <= '0;
            cur_last  <= 1'b0;
            chunk_q   <= '0;
            n_q       <= '0;
            last_idx  <= '0;
            last_word <= '0;
            flags     <= '0;
            count     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    alt_q <= alt_mode;
                    n_q   <= '0;
                    flags <= '0;
                    count <= '0;
                    state <= ST_WAIT;
                end
                ST_WAIT: if (seg_valid) begin
                    cur_addr <= seg_addr;
                    rem      <= seg_len;
                    cur_last <= seg_last;
                    if (misaligned(alt_q, seg_addr[1:0], seg_len[1:0])) begin
                        flags.fail      <= 1'b1;
                        flags.align_err <= 1'b1;
                        if (seg_last) begin
                            flags.done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end else if (seg_len == '0) begin
                        state <= seg_last ? ST_FIN : ST_WAIT;
                    end else begin
                        state <= ST_ADDR;
                    end
                end
                ST_ADDR, ST_ADDR2: begin
                    if (n_q == LIMIT) begin
                        flags.fail <= 1'b1;
                        if (cur_last) begin
                            flags.done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end else if (state == ST_ADDR) begin
                        chunk_q <= chunk;
                        state   <= ST_CNT;
                    end else begin
                        state <= ST_CNT2;
                    end
                end
                ST_CNT, ST_CNT2: begin
                    n_q       <= n_q + 1'b1;
                    last_idx  <= cnt_slot;
                    last_word <= wr_data;
                    if (state == ST_CNT && chunk_q.split) begin
                        state <= ST_ADDR2;
                    end else begin
                        cur_addr <= cur_addr + ADDR_W'(chunk_q.len);
                        rem      <= rem - LEN_W'(chunk_q.len);
                        if (!seg_end)
                            state <= ST_ADDR;
                        else
                            state <= cur_last ? ST_FIN : ST_WAIT;
                    end
                end
                ST_FIN: begin
                    flags.done  <= 1'b1;
                    flags.empty <= (n_q == '0);
                    count       <= n_q;
                    state       <= ST_IDLE;
                end
                ST_DRAIN: if (seg_valid && seg_last) begin
                    flags.done <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a region being described never runs past the 64 KiB window it starts in
    p_chunk_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CNT) |->
            (({2'b0, cur_addr[15:0]} + {1'b0, chunk_q.len}) <= 18'h10000)
            && (chunk_q.len != '0));

    // R1: every write lands inside the descriptor table
    p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < 2 * MAX_ENTRIES));

    // R6: an abandoned table reports no descriptors
    p_fail_count_zero_r6: assert property (@(posedge clk) disable iff (rst)
        flags.fail |-> (count == '0));

    // R10: finished results stay put until a new start
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (flags.done && !start) |=> (flags.done && $stable(count) && $stable(flags)));

    // R11: taking a fragment and writing a descriptor never share a cycle
    p_ready_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        seg_ready |-> !wr_en);

endmodule

// File: rtl/sgd_segmenter.sv
module sgd_segmenter
    import sgd_pkg::*;
#(
    parameter int unsigned LEN_W       = 32,
    parameter int unsigned MAX_ENTRIES = 8,
    localparam int unsigned IDX_W      = $clog2(2 * MAX_ENTRIES),
    localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              alt_mode,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [31:0]       seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic              fail,
    output logic              empty,
    output logic              align_err,
    output logic [CNT_W-1:0]  count
);

    chunk_t            chunk;
    logic              alt_q;
    logic [31:0]       cur_addr;
    logic [LEN_W-1:0]  rem;
    result_flags_t     flags;

    sgd_chunker #(
        .LEN_W (LEN_W)
    ) u_chunker (
        .alt     (alt_q),
        .addr_lo (cur_addr[15:0]),
        .rem     (rem),
        .chunk   (chunk)
    );

    sgd_ctrl #(
        .LEN_W       (LEN_W),
        .MAX_ENTRIES (MAX_ENTRIES),
        .IDX_W       (IDX_W),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .alt_mode  (alt_mode),
        .seg_valid (seg_valid),
        .seg_ready (seg_ready),
        .seg_addr  (seg_addr),
        .seg_len   (seg_len),
        .seg_last  (seg_last),
        .chunk     (chunk),
        .alt_q     (alt_q),
        .cur_addr  (cur_addr),
        .rem       (rem),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .flags     (flags),
        .count     (count)
    );

    assign done      = flags.done;
    assign fail      = flags.fail;
    assign empty     = flags.empty;
    assign align_err = flags.align_err;

endmodule

// File: tb/sgd_segmenter_tb.sv
module sgd_segmenter_tb;

    localparam int MAXE  = 8;
    localparam int LEN_W = 32;
    localparam int IDX_W = $clog2(2 * MAXE);
    localparam int CNT_W = $clog2(MAXE + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic alt_mode = 1'b0;
    logic seg_valid = 1'b0;
    logic seg_ready;
    logic [31:0] seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0] wr_data;
    logic done, fail, empty, align_err;
    logic [CNT_W-1:0] count;

    always #2 clk = ~clk;

    sgd_segmenter #(.LEN_W(LEN_W), .MAX_ENTRIES(MAXE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .alt_mode(alt_mode),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .done(done), .fail(fail), .empty(empty),
        .align_err(align_err), .count(count)
    );

    typedef struct { logic [31:0] a; logic [31:0] l; } seg_s;
    typedef struct { int idx; logic [31:0] d; } wr_s;

    seg_s segs[$];
    wr_s  expq[$];
    int   checks = 0;
    int   fails  = 0;
    string cur_tag = "R1";

    int          e_count;
    logic        e_fail, e_empty, e_err;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (expq.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected write"}, wr_data, 32'hDEAD_0000);
            end else begin
                wr_s w;
                w = expq.pop_front();
                check(int'(wr_idx) == w.idx, {cur_tag, " write index"}, 32'(wr_idx), 32'(w.idx));
                check(wr_data == w.d, {cur_tag, " write data"}, wr_data, w.d);
            end
        end
    end

    task automatic model(input logic alt);
        int n = 0;
        int li = 0;
        logic [31:0] lw = '0;
        logic stop = 1'b0;
        e_fail = 1'b0; e_err = 1'b0; e_empty = 1'b0;
        foreach (segs[i]) begin
            logic [31:0] a;
            logic [31:0] r;
            if (stop) continue;
            a = segs[i].a;
            r = segs[i].l;
            if (alt ? ((a[1:0] != 0) || (r[1:0] != 0)) : (a[0] || r[0])) begin
                e_err = 1'b1; e_fail = 1'b1; stop = 1'b1;
                continue;
            end
            while (r != 0 && !stop) begin
                logic [31:0] tb;
                logic [31:0] c;
                tb = 32'h10000 - {16'd0, a[15:0]};
                c  = (r < tb) ? r : tb;
                if (n >= MAXE) begin e_fail = 1'b1; stop = 1'b1; break; end
                expq.push_back('{2*n, a});
                if (!alt && c == 32'h10000) begin
                    expq.push_back('{2*n+1, 32'h8000});
                    n++;
                    if (n >= MAXE) begin e_fail = 1'b1; stop = 1'b1; break; end
                    expq.push_back('{2*n, a + 32'h8000});
                    expq.push_back('{2*n+1, 32'h8000});
                    li = 2*n+1; lw = 32'h8000; n++;
                end else begin
                    logic [31:0] w;
                    w = alt ? (((c >> 2) - 32'd1) << 16) : (c & 32'hFFFF);
                    expq.push_back('{2*n+1, w});
                    li = 2*n+1; lw = w; n++;
                end
                a = a + c;
                r = r - c;
            end
        end
        if (e_fail) e_count = 0;
        else begin
            e_count = n;
            e_empty = (n == 0);
            if (n != 0 && !alt) expq.push_back('{li, lw | 32'h8000_0000});
        end
    endtask

    task automatic run_table(input logic alt, input string tag);
        cur_tag = tag;
        model(alt);
        @(negedge clk);
        start = 1'b1; alt_mode = alt;
        @(negedge clk);
        start = 1'b0; alt_mode = ~alt;
        foreach (segs[i]) begin
            seg_valid = 1'b1;
            seg_addr  = segs[i].a;
            seg_len   = segs[i].l;
            seg_last  = (i == segs.size() - 1);
            while (!seg_ready) @(negedge clk);
            @(negedge clk);
            seg_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        check(fail == e_fail, {tag, " fail flag"}, 32'(fail), 32'(e_fail));
        check(empty == e_empty, {tag, " empty flag (R8)"}, 32'(empty), 32'(e_empty));
        check(align_err == e_err, {tag, " align flag (R9)"}, 32'(align_err), 32'(e_err));
        check(int'(count) == e_count, {tag, " count (R10)"}, 32'(count), 32'(e_count));
        check(expq.size() == 0, {tag, " missing writes"}, 32'(expq.size()), 32'd0);
        expq.delete();
        // R10: results held while idle, stray valid ignored (R11)
        seg_valid = 1'b1;
        repeat (4) @(negedge clk);
        check(done && !seg_ready && int'(count) == e_count && fail == e_fail,
              {tag, " R10 hold / R11 idle"}, 32'(count), 32'(e_count));
        seg_valid = 1'b0;
        segs.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !fail && !wr_en && !seg_ready && count == 0, "R10 reset state",
              {28'd0, done, fail, wr_en, seg_ready}, 32'd0);

        // R1 R3 R5: one small fragment
        segs.push_back('{32'h1000_0000, 32'h200});
        run_table(1'b0, "R1 R3 R5 single");

        // R2: crossing a 64 KiB boundary
        segs.push_back('{32'h0001_FF00, 32'h300});
        run_table(1'b0, "R2 boundary");

        // R8: zero-length fragment in the middle
        segs.push_back('{32'h0000_0100, 32'h10});
        segs.push_back('{32'h0000_5000, 32'h0});
        segs.push_back('{32'h0000_2000, 32'h20});
        run_table(1'b0, "R8 mid-zero");

        // R4: full window, then window plus half
        segs.push_back('{32'h0003_0000, 32'h10000});
        segs.push_back('{32'h0005_0000, 32'h18000});
        run_table(1'b0, "R4 full window");

        // R7: alternate format, boundary and full window
        segs.push_back('{32'h0004_FFF0, 32'h20});
        segs.push_back('{32'h0006_0000, 32'h10000});
        run_table(1'b1, "R7 alternate");

        // R8: empty table
        segs.push_back('{32'h0000_0000, 32'h0});
        run_table(1'b0, "R8 empty");

        // R6: exactly MAX entries succeed
        for (int k = 0; k < MAXE; k++) segs.push_back('{32'h100 * k, 32'h2});
        run_table(1'b0, "R6 at limit");

        // R6: one too many
        for (int k = 0; k <= MAXE; k++) segs.push_back('{32'h100 * k, 32'h2});
        run_table(1'b0, "R6 overflow");

        // R6 with R4: second half of a split hits the limit, then drain
        for (int k = 0; k < MAXE - 1; k++) segs.push_back('{32'h1000 * k, 32'h10});
        segs.push_back('{32'h0007_0000, 32'h10000});
        segs.push_back('{32'h0000_0100, 32'h4});
        run_table(1'b0, "R6 R4 split at limit");

        // R9: odd length in standard format, then drain
        segs.push_back('{32'h0000_0400, 32'h8});
        segs.push_back('{32'h0000_0800, 32'h7});
        segs.push_back('{32'h0000_0900, 32'h8});
        run_table(1'b0, "R9 odd length");

        // R9: alternate format needs 4-byte alignment
        segs.push_back('{32'h0000_0402, 32'h8});
        run_table(1'b1, "R9 alt address");

        // R7: alternate table spanning several fragments
        segs.push_back('{32'h0008_0000, 32'h4});
        segs.push_back('{32'h0009_FFFC, 32'h8});
        run_table(1'b1, "R7 alt small");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule